// File: doc/BRIEF.md
# Scrolled Tile Map Address Generator

This block turns a screen pixel position into the address of the tile-map byte that covers that pixel once the display has been scrolled. It sits in the fetch path of a tile renderer. Each cycle the block can take a screen coordinate, a 9-bit horizontal scroll, a 9-bit vertical scroll and a two-bit starting map choice. One cycle later it returns the map byte address and the pixel offset inside the 8x8 tile.

The four 1 KiB maps form a plane 512 pixels wide and 480 lines tall. Maps sit at 0x2000 and 0x2400 side by side, and at 0x2800 and 0x2C00 below them. If the scrolled column runs past the right edge of a map, the fetch moves into the map beside it. The same happens when the sum crosses the 9-bit boundary, so the wrap is seamless in both directions. If the scrolled line runs past line 240 of a map, the fetch moves to the map above or below it. The 0x800 address bit holds the vertical map choice.

Top module: `tile_map_addr_gen`

## Requirements
- R1: After synchronous reset, `out_valid` is 0, `map_addr` is 0x2000, and both fine offsets are 0.
- R2: `out_valid` equals the `in_valid` sampled on the previous rising edge. The result belongs to the inputs sampled on that same edge.
- R3: Let H = (pix_x + scroll_h + 256*base_sel[0]) mod 512. `map_addr[4:0]` = (H mod 256)/8 and `fine_x` = H mod 8.
- R4: `map_addr[10]` (worth 0x400) = H/256. A horizontal overflow past 255 therefore toggles between the 0x2000 and 0x2400 columns of maps in either direction.
- R5: Let V = (pix_y + scroll_v + 240*base_sel[1]) mod 480. `map_addr[11]` (worth 0x800) = V/240, `map_addr[9:5]` = (V mod 240)/8, and `fine_y` = V mod 8.
- R6: Vertical scroll values of 480 or more are reduced modulo 480. So 480 acts as 0, and 511 acts as 31.
- R7: Every valid result lies in 0x2000..0x2FFF, and its row field (`map_addr[9:5]`) never exceeds 29.
- R8: While `in_valid` is 0, `map_addr`, `fine_x` and `fine_y` hold their last values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs carry a pixel request this cycle |
| pix_x | input | 8 | Screen column, 0..255 |
| pix_y | input | 8 | Screen line, 0..239 |
| scroll_h | input | 9 | Horizontal scroll in pixels |
| scroll_v | input | 9 | Vertical scroll in lines |
| base_sel | input | 2 | Starting map: bit 0 horizontal, bit 1 vertical |
| out_valid | output | 1 | Result registered from a valid request |
| map_addr | output | 14 | Tile-map byte address |
| fine_x | output | 3 | Pixel column inside the tile |
| fine_y | output | 3 | Pixel line inside the tile |

## Verification
Every result is due exactly one rising edge after its request is sampled, because a single register sits between the inputs and the outputs. The bench drives each request at a falling edge. It waits for the next rising edge and compares at the falling edge that follows, so it reads the outputs half a cycle after they settle. Hold behaviour is checked one cycle after `in_valid` drops, while the other inputs are changed at the same time. Reset values are checked before any request is issued.

// File: rtl/tmag_pkg.sv
package tmag_pkg;
    localparam int PIX_W     = 8;
    localparam int SCROLL_W  = 9;
    localparam int TILE_LOG2 = 3;
    localparam int MAP_COLS  = 32;
    localparam int MAP_ROWS  = 30;
    localparam int COL_W     = $clog2(MAP_COLS);
    localparam int ROW_W     = $clog2(MAP_ROWS);
    localparam int MAP_LINES = MAP_ROWS << TILE_LOG2;
    localparam int V_SUM_W   = SCROLL_W + 1;
    localparam int ADDR_W    = 14;
    localparam logic [ADDR_W-1:0] ADDR_BASE = 14'h2000;
    localparam int H_SEL_BIT = COL_W + ROW_W;
    localparam int V_SEL_BIT = H_SEL_BIT + 1;

    typedef struct packed {
        logic                 sel;
        logic [COL_W-1:0]     tile;
        logic [TILE_LOG2-1:0] fine;
    } axis_t;

    typedef struct packed {
        logic [ADDR_W-1:0]    addr;
        logic [TILE_LOG2-1:0] fx;
        logic [TILE_LOG2-1:0] fy;
    } result_t;

    function automatic logic [ADDR_W-1:0] compose(axis_t h, axis_t v);
        logic [ADDR_W-1:0] a;
        a = ADDR_BASE;
        a[V_SEL_BIT] = v.sel;
        a[H_SEL_BIT] = h.sel;
        a[H_SEL_BIT-1:COL_W] = v.tile;
        a[COL_W-1:0] = h.tile;
        return a;
    endfunction
endpackage

// File: rtl/tmag_hwrap.sv
module tmag_hwrap
    import tmag_pkg::*;
(
    input  logic [PIX_W-1:0]    pos,
    input  logic [SCROLL_W-1:0] scroll,
    input  logic                base_bit,
    output axis_t               axis
);
    logic [SCROLL_W-1:0] hpos;

    always_comb begin
        hpos = {base_bit, {PIX_W{1'b0}}} + {1'b0, pos} + scroll;
        axis.sel  = hpos[SCROLL_W-1];
        axis.tile = hpos[PIX_W-1:TILE_LOG2];
        axis.fine = hpos[TILE_LOG2-1:0];
    end
endmodule

// File: rtl/tmag_vwrap.sv
module tmag_vwrap
    import tmag_pkg::*;
(
    input  logic [PIX_W-1:0]    pos,
    input  logic [SCROLL_W-1:0] scroll,
    input  logic                base_bit,
    output axis_t               axis
);
    localparam logic [V_SUM_W-1:0] ONE_MAP  = V_SUM_W'(MAP_LINES);
    localparam logic [V_SUM_W-1:0] PERIOD   = V_SUM_W'(2 * MAP_LINES);
    localparam logic [V_SUM_W-1:0] PERIOD_2 = V_SUM_W'(4 * MAP_LINES);

    logic [V_SUM_W-1:0] raw, red, in_map;
    logic [PIX_W-1:0]   line;

    always_comb begin
        raw = {2'b00, pos} + {1'b0, scroll} + (base_bit ? ONE_MAP : '0);
        if (raw >= PERIOD_2)    red = raw - PERIOD_2;
        else if (raw >= PERIOD) red = raw - PERIOD;
        else                    red = raw;
        axis.sel  = (red >= ONE_MAP);
        in_map    = axis.sel ? red - ONE_MAP : red;
        line      = PIX_W'(in_map);
        axis.tile = line[PIX_W-1:TILE_LOG2];
        axis.fine = line[TILE_LOG2-1:0];
    end
endmodule

// File: rtl/tile_map_addr_gen.sv
module tile_map_addr_gen
    import tmag_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [PIX_W-1:0]     pix_x,
    input  logic [PIX_W-1:0]     pix_y,
    input  logic [SCROLL_W-1:0]  scroll_h,
    input  logic [SCROLL_W-1:0]  scroll_v,
    input  logic [1:0]           base_sel,
    output logic                 out_valid,
    output logic [ADDR_W-1:0]    map_addr,
    output logic [TILE_LOG2-1:0] fine_x,
    output logic [TILE_LOG2-1:0] fine_y
);
    axis_t   h_ax, v_ax;
    result_t nxt, res;

    tmag_hwrap u_h (.pos(pix_x), .scroll(scroll_h), .base_bit(base_sel[0]), .axis(h_ax));
    tmag_vwrap u_v (.pos(pix_y), .scroll(scroll_v), .base_bit(base_sel[1]), .axis(v_ax));

    always_comb begin
        nxt.addr = compose(h_ax, v_ax);
        nxt.fx   = h_ax.fine;
        nxt.fy   = v_ax.fine;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res       <= '{addr: ADDR_BASE, fx: '0, fy: '0};
        end else begin
            out_valid <= in_valid;
            if (in_valid) res <= nxt;
        end
    end

    assign map_addr = res.addr;
    assign fine_x   = res.fx;
    assign fine_y   = res.fy;

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r3_fine_x: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> fine_x == $past(pix_x[2:0] + scroll_h[2:0]));
    a_r7_range: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> map_addr[ADDR_W-1:ADDR_W-2] == 2'b10);
    a_r7_row_limit: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> map_addr[H_SEL_BIT-1:COL_W] <= ROW_W'(MAP_ROWS - 1));
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(map_addr) && $stable(fine_x) && $stable(fine_y));
endmodule

// File: tb/tb_tile_map_addr_gen.sv
module tb_tile_map_addr_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] pix_x = '0, pix_y = '0;
    logic [8:0] scroll_h = '0, scroll_v = '0;
    logic [1:0] base_sel = '0;
    logic       out_valid;
    logic [13:0] map_addr;
    logic [2:0] fine_x, fine_y;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tile_map_addr_gen dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_one(input int x, input int y, input int sx, input int sy, input int b);
        int h, v, vs, rp, ea;
        @(negedge clk);
        pix_x = 8'(x); pix_y = 8'(y); scroll_h = 9'(sx); scroll_v = 9'(sy);
        base_sel = 2'(b); in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        h  = (x + sx + 256 * (b % 2)) % 512;
        v  = (y + sy + 240 * (b / 2)) % 480;
        vs = v / 240;
        rp = v % 240;
        ea = 'h2000 + vs * 'h800 + (h / 256) * 'h400 + (rp / 8) * 32 + (h % 256) / 8;
        chk("R2 valid", int'(out_valid), 1);
        chk("R3 column", int'(map_addr[4:0]), (h % 256) / 8);
        chk("R3 fine_x", int'(fine_x), h % 8);
        chk("R4 hsel", int'(map_addr[10]), h / 256);
        chk("R5/R6 vertical", int'({map_addr[11], map_addr[9:5], fine_y}), vs * 256 + (rp / 8) * 8 + rp % 8);
        chk("R7 full addr", int'(map_addr), ea);
    endtask

    initial begin
        int sxs[9] = '{0, 1, 7, 8, 249, 255, 256, 300, 511};
        int sys[8] = '{0, 5, 239, 240, 471, 479, 480, 511};
        logic [13:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 valid", int'(out_valid), 0);
        chk("R1 addr", int'(map_addr), 'h2000);
        chk("R1 fine", int'({fine_x, fine_y}), 0);
        for (int b = 0; b < 4; b++)
            for (int s = 0; s < 9; s++)
                for (int x = 0; x < 256; x += 7)
                    run_one(x, 100, sxs[s], 0, b);
        for (int b = 0; b < 4; b++)
            for (int s = 0; s < 8; s++)
                for (int y = 0; y < 240; y += 5)
                    run_one(37, y, 20, sys[s], b);
        run_one(255, 239, 511, 511, 3);
        held = map_addr;
        @(negedge clk);
        in_valid = 1'b0; pix_x = 8'd3; pix_y = 8'd9; scroll_h = 9'd77; base_sel = 2'd1;
        @(posedge clk);
        @(negedge clk);
        chk("R2 idle", int'(out_valid), 0);
        chk("R8 hold", int'(map_addr), int'(held));
        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (100000) @(posedge clk);
                tests++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule